// File: doc/BRIEF.md
# Flash command sequence decoder

This block sits behind the bus interface of a parallel flash device. It sees each byte write as a one-cycle strobe with the captured address and data. The strobe has already been synchronised and edge-detected. The block matches keyed address/data sequences of three, six and seven writes. From them it produces:

- a program-start pulse, followed by a byte-load window,
- entry into and exit from an identification mode,
- sticky lockout flags for a lower and an upper boot block,
- a chip-erase request.

Writes that arrive without a valid unlock prefix store nothing. Instead they raise a pulse that lets the write timer start, so that reads behave as status polling. While identification mode is active, a read port returns the manufacturer code, the device code and the lock status of each boot block. The array, the write timer and the erase machinery lie outside the block. The `prog_done_i` input reports the end of a program cycle.

Top module: `flash_cmd_decoder`

## Requirements
- R1: The writes AA@5555, 55@2AAA, A0@5555 give one `prog_start_o` pulse and set `load_en_o`. Only address bits [14:0] take part in every keyed compare; the upper address bits are don't-care.
- R2: While `load_en_o` is high, no write is decoded as a command. Each write instead pulses `byte_load_o`, or `load_blocked_o` (see R10). A `prog_done_i` cycle clears `load_en_o`, and protection is armed again.
- R3: AA@5555, 55@2AAA, 90@5555 sets `id_mode_o`. AA@5555, 55@2AAA, F0@5555 clears it.
- R4: In identification mode, a read at address 0 gives 1F, at address 1 gives C4, and at any other address that is not a status address gives 00. Outside identification mode, `id_data_o` is 00.
- R5: In identification mode, a read at 00002 reports the lower block and a read at 7FFF2 reports the upper block. The value is FE when the block is unlocked and FF when it is locked.
- R6: The writes AA@5555, 55@2AAA, 80@5555, AA@5555, 55@2AAA, 40@5555 must be followed by a selecting write. 00 to address 00000 sets the lower lock; FF to address 7FFFF sets the upper lock. The matching set pulse fires, and lock flags never clear before reset.
- R7: AA@5555, 55@2AAA, 80@5555, AA@5555, 55@2AAA, 10@5555 pulses `chip_erase_o` only if neither lock is set. If a lock is set, the request is dropped.
- R8: A write that does not match the expected step returns the tracker to idle and pulses `poll_start_o`. The exception is AA@5555, which instead counts as step one of a new sequence, with no pulse.
- R9: Reset clears identification mode, byte-load mode and all pulses. It loads each lock flag from its preload parameter.
- R10: A boot block is 16K bytes: the bottom block has address bits [18:14] all zero, and the top block has them all one. A load to a locked block pulses `load_blocked_o` instead of `byte_load_o`.
- R11: Every pulse and level output changes one clock after the strobe edge that causes it, and each pulse lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_stb_i | input | 1 | One-cycle write strobe |
| wr_addr_i | input | 19 | Captured write address |
| wr_data_i | input | 8 | Captured write data |
| prog_done_i | input | 1 | End of program cycle |
| rd_addr_i | input | 19 | Read address for identification data |
| prog_start_o | output | 1 | Program unlock completed |
| load_en_o | output | 1 | Byte-load window open |
| byte_load_o | output | 1 | Accepted byte load |
| load_blocked_o | output | 1 | Byte load refused by a lock |
| poll_start_o | output | 1 | Unprotected write, start the timer for polling |
| id_mode_o | output | 1 | Identification mode active |
| id_data_o | output | 8 | Identification read data |
| lock_lo_set_o | output | 1 | Lower lock set command |
| lock_hi_set_o | output | 1 | Upper lock set command |
| lock_lo_o | output | 1 | Lower block locked |
| lock_hi_o | output | 1 | Upper block locked |
| chip_erase_o | output | 1 | Chip-erase request |

## Verification
Every pulse and level is registered. Each is therefore due in the cycle that follows the rising edge on which the strobe was sampled. `id_data_o` is combinational from `rd_addr_i` and that same registered state, so it is due in the same cycle. The bench drives each write on a falling edge and lets one rising edge pass. It compares every output at the next falling edge, where all results of that write are settled and none of the next write's results have appeared yet.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_U1, ST_U2, ST_E1, ST_E2, ST_E3, ST_SEL, ST_LOAD
  } seq_st_e;

  typedef struct packed {
    logic prog;
    logic id_on;
    logic id_off;
    logic erase;
    logic lock_lo;
    logic lock_hi;
    logic poll;
  } seq_ev_t;

  localparam int unsigned KEY_W = 15;
  localparam logic [KEY_W-1:0] KEY_A = 15'h5555;
  localparam logic [KEY_W-1:0] KEY_B = 15'h2AAA;
  localparam logic [7:0] D_UNLK1  = 8'hAA;
  localparam logic [7:0] D_UNLK2  = 8'h55;
  localparam logic [7:0] C_PROG   = 8'hA0;
  localparam logic [7:0] C_ID_ON  = 8'h90;
  localparam logic [7:0] C_ID_OFF = 8'hF0;
  localparam logic [7:0] C_EXT    = 8'h80;
  localparam logic [7:0] C_LOCK   = 8'h40;
  localparam logic [7:0] C_ERASE  = 8'h10;
  localparam logic [7:0] C_SEL_LO = 8'h00;
  localparam logic [7:0] C_SEL_HI = 8'hFF;
endpackage

// File: rtl/seq_tracker.sv
module seq_tracker
  import flash_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W = 19
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_stb_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic              prog_done_i,
  output seq_st_e           state_o,
  output seq_ev_t           ev_o
);
  seq_st_e st_q, st_d;
  seq_ev_t ev;
  logic    key_a, key_b, first, step2, sel_lo, sel_hi, bad;

  assign key_a  = wr_addr_i[KEY_W-1:0] == KEY_A;
  assign key_b  = wr_addr_i[KEY_W-1:0] == KEY_B;
  assign first  = key_a && (wr_data_i == D_UNLK1);
  assign step2  = key_b && (wr_data_i == D_UNLK2);
  assign sel_lo = (wr_addr_i == '0) && (wr_data_i == C_SEL_LO);
  assign sel_hi = (&wr_addr_i) && (wr_data_i == C_SEL_HI);

  always_comb begin
    st_d = st_q;
    ev   = '0;
    bad  = 1'b0;
    if (st_q == ST_LOAD) begin
      if (prog_done_i) st_d = ST_IDLE;
    end else if (wr_stb_i) begin
      unique case (st_q)
        ST_IDLE: if (first) st_d = ST_U1; else bad = 1'b1;
        ST_U1:   if (step2) st_d = ST_U2; else bad = 1'b1;
        ST_U2: begin
          if (key_a && wr_data_i == C_PROG) begin
            st_d = ST_LOAD; ev.prog = 1'b1;
          end else if (key_a && wr_data_i == C_ID_ON) begin
            st_d = ST_IDLE; ev.id_on = 1'b1;
          end else if (key_a && wr_data_i == C_ID_OFF) begin
            st_d = ST_IDLE; ev.id_off = 1'b1;
          end else if (key_a && wr_data_i == C_EXT) begin
            st_d = ST_E1;
          end else bad = 1'b1;
        end
        ST_E1: if (first) st_d = ST_E2; else bad = 1'b1;
        ST_E2: if (step2) st_d = ST_E3; else bad = 1'b1;
        ST_E3: begin
          if (key_a && wr_data_i == C_LOCK) st_d = ST_SEL;
          else if (key_a && wr_data_i == C_ERASE) begin
            st_d = ST_IDLE; ev.erase = 1'b1;
          end else bad = 1'b1;
        end
        ST_SEL: begin
          if (sel_lo) begin
            st_d = ST_IDLE; ev.lock_lo = 1'b1;
          end else if (sel_hi) begin
            st_d = ST_IDLE; ev.lock_hi = 1'b1;
          end else bad = 1'b1;
        end
        default: st_d = ST_IDLE;
      endcase
      // a stray AA@5555 restarts the unlock instead of being dropped
      if (bad) begin
        st_d    = first ? ST_U1 : ST_IDLE;
        ev.poll = !first;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;

  assign state_o = st_q;
  assign ev_o    = ev;

  p_load_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_LOAD && !prog_done_i) |=> st_q == ST_LOAD);
  p_load_exit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_LOAD && prog_done_i) |=> st_q == ST_IDLE);
  p_idle_no_strobe_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && !wr_stb_i) |=> st_q == ST_IDLE);
endmodule

// File: rtl/cmd_exec.sv
module cmd_exec
  import flash_cmd_pkg::*;
#(
  parameter int unsigned BLK_W        = 5,
  parameter bit          LOCK_LO_INIT = 1'b0,
  parameter bit          LOCK_HI_INIT = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_stb_i,
  input  logic [BLK_W-1:0] blk_addr_i,
  input  logic             in_load_i,
  input  seq_ev_t          ev_i,
  output logic             prog_start_o,
  output logic             byte_load_o,
  output logic             load_blocked_o,
  output logic             poll_start_o,
  output logic             id_mode_o,
  output logic             lock_lo_set_o,
  output logic             lock_hi_set_o,
  output logic             lock_lo_o,
  output logic             lock_hi_o,
  output logic             chip_erase_o
);
  logic in_lo, in_hi, blocked, any_lock, ld;
  logic lock_lo_q, lock_hi_q, id_q;

  assign in_lo    = blk_addr_i == '0;
  assign in_hi    = &blk_addr_i;
  assign blocked  = (in_lo && lock_lo_q) || (in_hi && lock_hi_q);
  assign any_lock = lock_lo_q || lock_hi_q;
  assign ld       = wr_stb_i && in_load_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prog_start_o   <= 1'b0;
      byte_load_o    <= 1'b0;
      load_blocked_o <= 1'b0;
      poll_start_o   <= 1'b0;
      lock_lo_set_o  <= 1'b0;
      lock_hi_set_o  <= 1'b0;
      chip_erase_o   <= 1'b0;
      id_q           <= 1'b0;
      lock_lo_q      <= LOCK_LO_INIT;
      lock_hi_q      <= LOCK_HI_INIT;
    end else begin
      prog_start_o   <= ev_i.prog;
      byte_load_o    <= ld && !blocked;
      load_blocked_o <= ld && blocked;
      poll_start_o   <= ev_i.poll;
      lock_lo_set_o  <= ev_i.lock_lo;
      lock_hi_set_o  <= ev_i.lock_hi;
      chip_erase_o   <= ev_i.erase && !any_lock;
      if (ev_i.id_on)        id_q <= 1'b1;
      else if (ev_i.id_off)  id_q <= 1'b0;
      if (ev_i.lock_lo) lock_lo_q <= 1'b1;
      if (ev_i.lock_hi) lock_hi_q <= 1'b1;
    end
  end

  assign lock_lo_o = lock_lo_q;
  assign lock_hi_o = lock_hi_q;
  assign id_mode_o = id_q;

  p_lock_lo_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_lo_q |=> lock_lo_q);
  p_lock_hi_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_hi_q |=> lock_hi_q);
  p_erase_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chip_erase_o |-> !lock_lo_q && !lock_hi_q);
  p_prog_enters_load_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_start_o |-> in_load_i);
  p_no_load_outside_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_load_i |=> !byte_load_o && !load_blocked_o);
  p_pulse_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({prog_start_o, byte_load_o, load_blocked_o, poll_start_o,
              lock_lo_set_o, lock_hi_set_o, chip_erase_o}));
endmodule

// File: rtl/id_reader.sv
module id_reader #(
  parameter int unsigned ADDR_W   = 19,
  parameter logic [7:0]  MFG_CODE = 8'h1F,
  parameter logic [7:0]  DEV_CODE = 8'hC4
) (
  input  logic              id_mode_i,
  input  logic              lock_lo_i,
  input  logic              lock_hi_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        data_o
);
  localparam logic [ADDR_W-1:0] A_MFG   = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_DEV   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_ST_LO = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_ST_HI = {{(ADDR_W-4){1'b1}}, 4'h2};

  always_comb begin
    data_o = 8'h00;
    if (id_mode_i) begin
      if (rd_addr_i == A_MFG)        data_o = MFG_CODE;
      else if (rd_addr_i == A_DEV)   data_o = DEV_CODE;
      else if (rd_addr_i == A_ST_LO) data_o = {7'h7F, lock_lo_i};
      else if (rd_addr_i == A_ST_HI) data_o = {7'h7F, lock_hi_i};
    end
  end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W       = 19,
  parameter int unsigned BOOT_W       = 14,
  parameter bit          LOCK_LO_INIT = 1'b0,
  parameter bit          LOCK_HI_INIT = 1'b0,
  parameter logic [7:0]  MFG_CODE     = 8'h1F,
  parameter logic [7:0]  DEV_CODE     = 8'hC4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_stb_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic              prog_done_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              prog_start_o,
  output logic              load_en_o,
  output logic              byte_load_o,
  output logic              load_blocked_o,
  output logic              poll_start_o,
  output logic              id_mode_o,
  output logic [7:0]        id_data_o,
  output logic              lock_lo_set_o,
  output logic              lock_hi_set_o,
  output logic              lock_lo_o,
  output logic              lock_hi_o,
  output logic              chip_erase_o
);
  localparam int unsigned BLK_W = ADDR_W - BOOT_W;

  seq_st_e state;
  seq_ev_t ev;
  logic    in_load;

  seq_tracker #(.ADDR_W(ADDR_W)) u_trk (
    .clk_i, .rst_ni, .wr_stb_i, .wr_addr_i, .wr_data_i, .prog_done_i,
    .state_o(state), .ev_o(ev)
  );

  assign in_load   = state == ST_LOAD;
  assign load_en_o = in_load;

  cmd_exec #(.BLK_W(BLK_W), .LOCK_LO_INIT(LOCK_LO_INIT),
             .LOCK_HI_INIT(LOCK_HI_INIT)) u_exec (
    .clk_i, .rst_ni, .wr_stb_i,
    .blk_addr_i(wr_addr_i[ADDR_W-1:BOOT_W]),
    .in_load_i(in_load), .ev_i(ev),
    .prog_start_o, .byte_load_o, .load_blocked_o, .poll_start_o,
    .id_mode_o, .lock_lo_set_o, .lock_hi_set_o, .lock_lo_o, .lock_hi_o,
    .chip_erase_o
  );

  id_reader #(.ADDR_W(ADDR_W), .MFG_CODE(MFG_CODE), .DEV_CODE(DEV_CODE)) u_id (
    .id_mode_i(id_mode_o), .lock_lo_i(lock_lo_o), .lock_hi_i(lock_hi_o),
    .rd_addr_i, .data_o(id_data_o)
  );

  p_id_mode_stable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_stb_i |=> $stable(id_mode_o));
  p_load_after_prog_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(load_en_o) |-> prog_start_o);
endmodule

// File: tb/flash_cmd_decoder_tb_top.sv
module flash_cmd_decoder_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic stb = 1'b0, done = 1'b0;
  logic [18:0] wa = '0, ra = '0;
  logic [7:0]  wd = '0;
  logic prog_start, load_en, byte_load, load_blocked, poll_start, id_mode;
  logic lock_lo_set, lock_hi_set, lock_lo, lock_hi, chip_erase;
  logic [7:0] id_data;
  logic p_lo, p_hi, p_ps, p_ld, p_bl, p_po, p_id, p_ls, p_hs, p_ce, p_le;
  logic [7:0] p_dat;

  int checks = 0, fails = 0;
  int ms = 0;
  bit m_id = 0, m_lo = 0, m_hi = 0;
  bit e_prog, e_load, e_blk, e_poll, e_llo, e_lhi, e_erase;

  always #2 clk = ~clk;

  flash_cmd_decoder dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_stb_i(stb), .wr_addr_i(wa), .wr_data_i(wd),
    .prog_done_i(done), .rd_addr_i(ra), .prog_start_o(prog_start),
    .load_en_o(load_en), .byte_load_o(byte_load), .load_blocked_o(load_blocked),
    .poll_start_o(poll_start), .id_mode_o(id_mode), .id_data_o(id_data),
    .lock_lo_set_o(lock_lo_set), .lock_hi_set_o(lock_hi_set),
    .lock_lo_o(lock_lo), .lock_hi_o(lock_hi), .chip_erase_o(chip_erase)
  );

  flash_cmd_decoder #(.LOCK_HI_INIT(1'b1)) dut_pre_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_stb_i(stb), .wr_addr_i(wa), .wr_data_i(wd),
    .prog_done_i(done), .rd_addr_i(ra), .prog_start_o(p_ps),
    .load_en_o(p_le), .byte_load_o(p_ld), .load_blocked_o(p_bl),
    .poll_start_o(p_po), .id_mode_o(p_id), .id_data_o(p_dat),
    .lock_lo_set_o(p_ls), .lock_hi_set_o(p_hs),
    .lock_lo_o(p_lo), .lock_hi_o(p_hi), .chip_erase_o(p_ce)
  );

  task automatic chk(input string req, input string what, input logic [7:0] act,
                     input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] id_exp(input logic [18:0] a);
    if (!m_id) return 8'h00;
    if (a == 19'h0) return 8'h1F;
    if (a == 19'h1) return 8'hC4;
    if (a == 19'h2) return m_lo ? 8'hFF : 8'hFE;
    if (a == 19'h7FFF2) return m_hi ? 8'hFF : 8'hFE;
    return 8'h00;
  endfunction

  task automatic model(input bit s, input logic [18:0] a, input logic [7:0] d, input bit dn);
    bit first, kb, ka, bad, blk;
    {e_prog, e_load, e_blk, e_poll, e_llo, e_lhi, e_erase} = '0;
    ka = a[14:0] == 15'h5555;
    first = ka && d == 8'hAA;
    kb = a[14:0] == 15'h2AAA && d == 8'h55;
    bad = 0;
    if (ms == 7) begin
      if (s) begin
        blk = (a[18:14] == 5'h00 && m_lo) || (a[18:14] == 5'h1F && m_hi);
        if (blk) e_blk = 1; else e_load = 1;
      end
      if (dn) ms = 0;
    end else if (s) begin
      case (ms)
        0: if (first) ms = 1; else bad = 1;
        1: if (kb) ms = 2; else bad = 1;
        2: if (ka && d == 8'hA0) begin ms = 7; e_prog = 1; end
           else if (ka && d == 8'h90) begin ms = 0; m_id = 1; end
           else if (ka && d == 8'hF0) begin ms = 0; m_id = 0; end
           else if (ka && d == 8'h80) ms = 3;
           else bad = 1;
        3: if (first) ms = 4; else bad = 1;
        4: if (kb) ms = 5; else bad = 1;
        5: if (ka && d == 8'h40) ms = 6;
           else if (ka && d == 8'h10) begin ms = 0; e_erase = !(m_lo || m_hi); end
           else bad = 1;
        default:
           if (a == 19'h0 && d == 8'h00) begin ms = 0; e_llo = 1; m_lo = 1; end
           else if (a == 19'h7FFFF && d == 8'hFF) begin ms = 0; e_lhi = 1; m_hi = 1; end
           else bad = 1;
      endcase
      if (bad) begin
        if (first) ms = 1; else begin ms = 0; e_poll = 1; end
      end
    end
  endtask

  // one clock: drive at falling edge, sample at the next falling edge
  task automatic cyc(input bit s, input logic [18:0] a, input logic [7:0] d,
                     input bit dn, input logic [18:0] r);
    stb = s; wa = a; wd = d; done = dn; ra = r;
    model(s, a, d, dn);
    @(posedge clk);
    @(negedge clk);
    chk("R1", "prog_start", {7'h0, prog_start}, {7'h0, e_prog});
    chk("R2", "load_en", {7'h0, load_en}, {7'h0, ms == 7});
    chk("R2", "byte_load", {7'h0, byte_load}, {7'h0, e_load});
    chk("R10", "load_blocked", {7'h0, load_blocked}, {7'h0, e_blk});
    chk("R8", "poll_start", {7'h0, poll_start}, {7'h0, e_poll});
    chk("R3", "id_mode", {7'h0, id_mode}, {7'h0, m_id});
    chk("R6", "lock_lo_set", {7'h0, lock_lo_set}, {7'h0, e_llo});
    chk("R6", "lock_hi_set", {7'h0, lock_hi_set}, {7'h0, e_lhi});
    chk("R6", "lock flags", {6'h0, lock_hi, lock_lo}, {6'h0, m_hi, m_lo});
    chk("R7", "chip_erase", {7'h0, chip_erase}, {7'h0, e_erase});
    chk((r == 19'h2 || r == 19'h7FFF2) ? "R5" : "R4", "id_data", id_data, id_exp(r));
    stb = 0; done = 0;
  endtask

  task automatic wr(input logic [18:0] a, input logic [7:0] d);
    cyc(1, a, d, 0, 19'h0);
  endtask
  task automatic idle(input logic [18:0] r);
    cyc(0, 19'h0, 8'h00, 0, r);
  endtask
  task automatic unlock2();
    wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55);
  endtask
  task automatic ext6(input logic [7:0] last);
    unlock2(); wr(19'h05555, 8'h80); unlock2(); wr(19'h05555, last);
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R9 reset state and preload
    chk("R9", "reset outputs",
        {prog_start, load_en, byte_load, poll_start, id_mode, lock_lo, lock_hi, chip_erase}, 8'h00);
    chk("R9", "preload lock_hi", {6'h0, p_hi, p_lo}, 8'h02);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 with upper address bits as don't-care
    wr(19'h45555, 8'hAA); wr(19'h72AAA, 8'h55); wr(19'h15555, 8'hA0);
    // R2 loads are not decoded, then the cycle ends
    wr(19'h05555, 8'hAA); wr(19'h12345, 8'h77);
    cyc(0, 19'h0, 8'h0, 1, 19'h0);
    idle(19'h0);
    chk("R11", "pulse cleared", {7'h0, prog_start}, 8'h00);
    // R3/R4/R5 identification mode and reads
    unlock2(); wr(19'h05555, 8'h90);
    idle(19'h0); idle(19'h1); idle(19'h2); idle(19'h7FFF2); idle(19'h00005);
    // R7 erase allowed with no lock
    ext6(8'h10);
    // R8 mismatch and restart
    wr(19'h05555, 8'hAA); wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55); wr(19'h05555, 8'h33);
    wr(19'h00100, 8'h12);
    // R6 lower lock, wrong select first
    ext6(8'h40); wr(19'h00001, 8'h00);
    ext6(8'h40); wr(19'h00000, 8'h00);
    idle(19'h2); idle(19'h7FFF2);
    ext6(8'h10);
    // R10 lower boundary
    unlock2(); wr(19'h05555, 8'hA0);
    wr(19'h03FFF, 8'h11); wr(19'h04000, 8'h22);
    cyc(0, 19'h0, 8'h0, 1, 19'h0);
    // upper lock and boundary
    ext6(8'h40); wr(19'h7FFFF, 8'hFF);
    idle(19'h7FFF2);
    unlock2(); wr(19'h05555, 8'hA0);
    wr(19'h7C000, 8'h11); wr(19'h7BFFF, 8'h22);
    cyc(0, 19'h0, 8'h0, 1, 19'h0);
    unlock2(); wr(19'h05555, 8'hF0);
    idle(19'h0);
    // random mix of keyed and stray writes
    for (int i = 0; i < 4000; i++) begin
      logic [18:0] a, r;
      logic [7:0] d;
      int k;
      a = 19'($urandom);
      d = 8'($urandom);
      k = $urandom_range(0, 13);
      case (k)
        0, 1, 2: begin a[14:0] = 15'h5555; d = 8'hAA; end
        3, 4:    begin a[14:0] = 15'h2AAA; d = 8'h55; end
        5: begin a[14:0] = 15'h5555; d = 8'hA0; end
        6: begin a[14:0] = 15'h5555; d = 8'h90; end
        7: begin a[14:0] = 15'h5555; d = 8'hF0; end
        8: begin a[14:0] = 15'h5555; d = 8'h80; end
        9: begin a[14:0] = 15'h5555; d = ($urandom_range(0, 1) != 0) ? 8'h40 : 8'h10; end
        10: begin a = ($urandom_range(0, 1) != 0) ? 19'h0 : 19'h7FFFF;
                  d = (a == 19'h0) ? 8'h00 : 8'hFF; end
        default: ;
      endcase
      case ($urandom_range(0, 4))
        0: r = 19'h0;
        1: r = 19'h1;
        2: r = 19'h2;
        3: r = 19'h7FFF2;
        default: r = 19'($urandom);
      endcase
      cyc($urandom_range(0, 3) != 0, a, d, $urandom_range(0, 7) == 0, r);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule